// File: doc/BRIEF.md
# SPI Flash Erase Sequencer

This block takes one erase request, given as a starting byte offset and a byte count, and walks it down to a series of erase commands on a serial flash. It first checks that the range lies inside the device and starts and ends on page boundaries. Then, for each step, it decides between erasing a single page and erasing an aligned group of eight pages. It sends the matching four-byte command and polls the device status until the device is no longer busy. After that it moves on by the amount just erased.

The page size need not be a power of two. The page index is therefore found by a small sequential divider. The device address is rebuilt on every step by shifting the page index left by a configured amount.

The serial link is reached through a byte-level handshake. The block holds a byte and a send request until the byte engine acknowledges it, and the acknowledge cycle carries the byte shifted in at the same time. The block also drives the chip select itself. Between status polls the chip select stays low for a programmable number of cycles.

Top module: `flash_erase_seq`

## Requirements
- R1: A request whose start plus length is larger than `cfgDevSize` is refused. `reject` pulses for one cycle, the chip select never rises, and `done` does not pulse.
- R2: A request whose start or length is not a whole multiple of `cfgPageSize` is refused the same way, with no command sent.
- R3: A step uses opcode 0x50 (eight-page erase) when the current page index is a multiple of 8 and at least 8 pages remain. Otherwise it uses opcode 0x81 (single-page erase).
- R4: Each erase command is exactly four bytes: the opcode, then bits 23:16 of the address, then bits 15:8 of the address, then 0x00. The address is the page index shifted left by `cfgPageShift`.
- R5: After each erase command the block reads status. Each read is a chip-select window holding the byte 0xD7 followed by a 0x00 filler byte, and the byte received with the filler is the status. Reads repeat until bit 7 of the status is 1, and the next erase starts only after that.
- R6: Before every status read, the chip select is low for exactly `cfgPollGap`+1 cycles.
- R7: After a ready status, the page index advances and the remaining count falls by 8 after an eight-page erase, or by 1 after a single-page erase. Erase commands therefore cover the requested range in ascending order.
- R8: `busy` is high from the cycle after a request is accepted until the final step. `done` pulses for exactly one cycle with `busy` low when the remaining count reaches zero. A zero-length request completes with `done` and sends no command.
- R9: The chip select stays high across every byte of a command or status read and falls between them. `spiSend` is only high under the chip select, and `spiTxByte` is held until `spiAck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | One-cycle request strobe, taken while idle |
| reqStart | input | AW | Starting byte offset |
| reqLen | input | AW | Byte count to erase |
| cfgDevSize | input | AW | Device size in bytes |
| cfgPageSize | input | PW | Page size in bytes, nonzero |
| cfgPageShift | input | SW | Left shift from page index to device address |
| cfgPollGap | input | GW | Extra idle cycles before each status read |
| spiCs | output | 1 | Chip select, active high |
| spiSend | output | 1 | Byte send request |
| spiTxByte | output | 8 | Byte to send |
| spiAck | input | 1 | Byte engine finished the current byte |
| spiRxByte | input | 8 | Byte received with the acknowledged byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| reject | output | 1 | One-cycle refusal pulse |

## Verification
The range walk is tried with starts that are aligned to eight pages, with starts that sit just below such an alignment, and with lengths under, at and above eight pages. This separates the choice of block erase from page erase and shows the switch over to block erase partway through a request. Three page geometries are used: a binary one and two non-binary ones with different shifts. They separate correct division and shifting from simple bit slicing of the byte offset. The responding engine returns a random number of not-ready statuses and random acknowledge delays, which exposes any erase issued before ready or any byte changed before its acknowledge. Out-of-range, misaligned-start, misaligned-length and zero-length requests cover each way a request can end without erasing.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

  localparam logic [7:0] OP_BLOCK_ERASE = 8'h50;
  localparam logic [7:0] OP_PAGE_ERASE  = 8'h81;
  localparam logic [7:0] OP_STATUS_RD   = 8'hD7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DIVSTART, ST_DIVLEN, ST_CMD, ST_GAP, ST_POLL, ST_ADV
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic divGo;
    logic divSelLen;
    logic captureLen;
    logic takeIdx;
    logic takeLeft;
    logic step;
    logic byteClr;
    logic byteInc;
    logic gapClr;
    logic pollMode;
  } dpCtl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic       divDone;
    logic       divRemZero;
    logic       divQuotZero;
    logic       overRange;
    logic       lastStep;
    logic       gapDone;
    logic [1:0] byteIdx;
  } dpStat_t;

endpackage

// File: rtl/flash_erase_div.sv
module flash_erase_div #(
  parameter int NW = 24,
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          go,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic [NW-1:0] quot,
  output logic          remZero,
  output logic          doneP
);
  localparam int CW = $clog2(NW + 1);

  logic [DW-1:0] remR;
  logic [NW-1:0] numR;
  logic [CW-1:0] cnt;
  logic          running;
  logic [DW:0]   trial;
  logic [DW:0]   diff;
  logic          ge;

  assign trial = {remR, numR[NW-1]};
  assign ge    = trial >= {1'b0, den};
  assign diff  = trial - {1'b0, den};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remR    <= '0;
      numR    <= '0;
      quot    <= '0;
      cnt     <= '0;
      running <= 1'b0;
      doneP   <= 1'b0;
    end else if (go) begin
      remR    <= '0;
      numR    <= num;
      quot    <= '0;
      cnt     <= CW'(NW);
      running <= 1'b1;
      doneP   <= 1'b0;
    end else if (running) begin
      remR <= ge ? diff[DW-1:0] : trial[DW-1:0];
      numR <= numR << 1;
      quot <= {quot[NW-2:0], ge};
      cnt  <= cnt - 1'b1;
      if (cnt == CW'(1)) begin
        running <= 1'b0;
        doneP   <= 1'b1;
      end
    end else begin
      doneP <= 1'b0;
    end
  end

  assign remZero = (remR == '0);
endmodule

// File: rtl/flash_erase_dp.sv
module flash_erase_dp
  import flash_erase_pkg::*;
#(
  parameter int AW = 24,
  parameter int PW = 12,
  parameter int SW = 4,
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCtl_t        ctl,
  output dpStat_t       stat,
  input  logic [AW-1:0] reqStart,
  input  logic [AW-1:0] reqLen,
  input  logic [AW-1:0] cfgDevSize,
  input  logic [PW-1:0] cfgPageSize,
  input  logic [SW-1:0] cfgPageShift,
  input  logic [GW-1:0] cfgPollGap,
  output logic [7:0]    spiTxByte
);
  localparam logic [AW-1:0] STEP_BLOCK = AW'(8);
  localparam logic [AW-1:0] STEP_PAGE  = AW'(1);

  logic [AW-1:0] lenReg;
  logic [AW-1:0] pageIdx;
  logic [AW-1:0] pagesLeft;
  logic [1:0]    byteIdx;
  logic [GW-1:0] gapCnt;
  logic [AW-1:0] divNum;
  logic [AW-1:0] quot;
  logic          divRemZero;
  logic          divDone;
  logic [AW:0]   rangeEnd;
  logic          useBlock;
  logic [AW-1:0] stepSize;
  logic [15:0]   addrTop;
  logic [7:0]    opcode;

  assign divNum = ctl.divSelLen ? lenReg : reqStart;

  flash_erase_div #(.NW(AW), .DW(PW)) u_div (
    .clk     (clk),
    .rstN    (rstN),
    .go      (ctl.divGo),
    .num     (divNum),
    .den     (cfgPageSize),
    .quot    (quot),
    .remZero (divRemZero),
    .doneP   (divDone)
  );

  assign rangeEnd = {1'b0, reqStart} + {1'b0, reqLen};
  assign useBlock = (pageIdx[2:0] == 3'd0) && (pagesLeft >= STEP_BLOCK);
  assign stepSize = useBlock ? STEP_BLOCK : STEP_PAGE;
  assign opcode   = useBlock ? OP_BLOCK_ERASE : OP_PAGE_ERASE;
  assign addrTop  = 16'((pageIdx << cfgPageShift) >> 8);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenReg    <= '0;
      pageIdx   <= '0;
      pagesLeft <= '0;
      byteIdx   <= '0;
      gapCnt    <= '0;
    end else begin
      if (ctl.captureLen) lenReg <= reqLen;
      if (ctl.takeIdx)    pageIdx <= quot;
      else if (ctl.step)  pageIdx <= pageIdx + stepSize;
      if (ctl.takeLeft)   pagesLeft <= quot;
      else if (ctl.step)  pagesLeft <= pagesLeft - stepSize;
      if (ctl.byteClr)      byteIdx <= '0;
      else if (ctl.byteInc) byteIdx <= byteIdx + 2'd1;
      if (ctl.gapClr)       gapCnt <= '0;
      else if (!stat.gapDone) gapCnt <= gapCnt + 1'b1;
    end
  end

  always_comb begin
    if (ctl.pollMode) begin
      spiTxByte = (byteIdx == 2'd0) ? OP_STATUS_RD : 8'h00;
    end else begin
      case (byteIdx)
        2'd0:    spiTxByte = opcode;
        2'd1:    spiTxByte = addrTop[15:8];
        2'd2:    spiTxByte = addrTop[7:0];
        default: spiTxByte = 8'h00;
      endcase
    end
  end

  assign stat.divDone     = divDone;
  assign stat.divRemZero  = divRemZero;
  assign stat.divQuotZero = (quot == '0);
  assign stat.overRange   = rangeEnd > {1'b0, cfgDevSize};
  assign stat.lastStep    = (pagesLeft == stepSize);
  assign stat.gapDone     = (gapCnt >= cfgPollGap);
  assign stat.byteIdx     = byteIdx;
endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
  import flash_erase_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       spiAck,
  input  logic [7:0] spiRxByte,
  input  dpStat_t    stat,
  output dpCtl_t     ctl,
  output logic       spiCs,
  output logic       spiSend,
  output logic       busy,
  output logic       done,
  output logic       reject
);
  seqState_t state, nextState;
  logic doneSet, rejSet;
  logic devReady;

  assign devReady = spiRxByte[7];

  always_comb begin
    ctl       = '0;
    nextState = state;
    doneSet   = 1'b0;
    rejSet    = 1'b0;
    case (state)
      ST_IDLE: if (reqValid) begin
        if (stat.overRange) rejSet = 1'b1;
        else begin
          ctl.captureLen = 1'b1;
          ctl.divGo      = 1'b1;
          nextState      = ST_DIVSTART;
        end
      end
      ST_DIVSTART: if (stat.divDone) begin
        if (!stat.divRemZero) begin
          rejSet    = 1'b1;
          nextState = ST_IDLE;
        end else begin
          ctl.takeIdx   = 1'b1;
          ctl.divGo     = 1'b1;
          ctl.divSelLen = 1'b1;
          nextState     = ST_DIVLEN;
        end
      end
      ST_DIVLEN: if (stat.divDone) begin
        if (!stat.divRemZero) begin
          rejSet    = 1'b1;
          nextState = ST_IDLE;
        end else begin
          ctl.takeLeft = 1'b1;
          ctl.byteClr  = 1'b1;
          if (stat.divQuotZero) begin
            doneSet   = 1'b1;
            nextState = ST_IDLE;
          end else nextState = ST_CMD;
        end
      end
      ST_CMD: if (spiAck) begin
        if (stat.byteIdx == 2'd3) begin
          ctl.byteClr = 1'b1;
          ctl.gapClr  = 1'b1;
          nextState   = ST_GAP;
        end else ctl.byteInc = 1'b1;
      end
      ST_GAP: if (stat.gapDone) begin
        ctl.byteClr = 1'b1;
        nextState   = ST_POLL;
      end
      ST_POLL: begin
        ctl.pollMode = 1'b1;
        if (spiAck) begin
          if (stat.byteIdx == 2'd1) begin
            ctl.byteClr = 1'b1;
            if (devReady) nextState = ST_ADV;
            else begin
              ctl.gapClr = 1'b1;
              nextState  = ST_GAP;
            end
          end else ctl.byteInc = 1'b1;
        end
      end
      ST_ADV: begin
        ctl.step = 1'b1;
        if (stat.lastStep) begin
          doneSet   = 1'b1;
          nextState = ST_IDLE;
        end else nextState = ST_CMD;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      done   <= 1'b0;
      reject <= 1'b0;
    end else begin
      state  <= nextState;
      done   <= doneSet;
      reject <= rejSet;
    end
  end

  assign spiCs   = (state == ST_CMD) || (state == ST_POLL);
  assign spiSend = spiCs;
  assign busy    = (state != ST_IDLE);
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import flash_erase_pkg::*;
#(
  parameter int AW = 24,
  parameter int PW = 12,
  parameter int SW = 4,
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic [AW-1:0] reqStart,
  input  logic [AW-1:0] reqLen,
  input  logic [AW-1:0] cfgDevSize,
  input  logic [PW-1:0] cfgPageSize,
  input  logic [SW-1:0] cfgPageShift,
  input  logic [GW-1:0] cfgPollGap,
  output logic          spiCs,
  output logic          spiSend,
  output logic [7:0]    spiTxByte,
  input  logic          spiAck,
  input  logic [7:0]    spiRxByte,
  output logic          busy,
  output logic          done,
  output logic          reject
);
  dpCtl_t  ctl;
  dpStat_t stat;

  flash_erase_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .spiAck    (spiAck),
    .spiRxByte (spiRxByte),
    .stat      (stat),
    .ctl       (ctl),
    .spiCs     (spiCs),
    .spiSend   (spiSend),
    .busy      (busy),
    .done      (done),
    .reject    (reject)
  );

  flash_erase_dp #(.AW(AW), .PW(PW), .SW(SW), .GW(GW)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .stat         (stat),
    .reqStart     (reqStart),
    .reqLen       (reqLen),
    .cfgDevSize   (cfgDevSize),
    .cfgPageSize  (cfgPageSize),
    .cfgPageShift (cfgPageShift),
    .cfgPollGap   (cfgPollGap),
    .spiTxByte    (spiTxByte)
  );
endmodule

// File: rtl/flash_erase_checker.sv
module flash_erase_checker (
  input logic       clk,
  input logic       rstN,
  input logic       spiCs,
  input logic       spiSend,
  input logic       spiAck,
  input logic [7:0] spiTxByte,
  input logic       busy,
  input logic       done,
  input logic       reject
);
  AST_SEND_UNDER_CS: assert property (@(posedge clk) disable iff (!rstN)
    spiSend |-> spiCs); // R9
  AST_TX_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (spiSend && !spiAck) |=> (spiSend && $stable(spiTxByte))); // R9
  AST_IDLE_NO_CS: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !spiCs); // R9
  AST_FIRST_BYTE_OPCODE: assert property (@(posedge clk) disable iff (!rstN)
    (spiSend && $rose(spiCs)) |-> (spiTxByte inside {8'h50, 8'h81, 8'hD7})); // R3
  AST_DONE_CLOSES_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy))); // R8
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    reject |-> (!busy && !spiCs)); // R1
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    !(done && reject)); // R2
endmodule

bind flash_erase_seq flash_erase_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .spiCs     (spiCs),
  .spiSend   (spiSend),
  .spiAck    (spiAck),
  .spiTxByte (spiTxByte),
  .busy      (busy),
  .done      (done),
  .reject    (reject)
);

// File: tb/flash_erase_seq_bench.sv
`timescale 1ns/1ps
module flash_erase_seq_bench;
  localparam int AW = 24, PW = 12, SW = 4, GW = 8;
  localparam int LOGN = 512;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [AW-1:0] reqStart = '0, reqLen = '0, cfgDevSize = '0;
  logic [PW-1:0] cfgPageSize = PW'(264);
  logic [SW-1:0] cfgPageShift = SW'(9);
  logic [GW-1:0] cfgPollGap = '0;
  logic spiCs, spiSend, busy, done, reject;
  logic [7:0] spiTxByte;
  logic spiAck = 1'b0;
  logic [7:0] spiRxByte = 8'h00;

  flash_erase_seq #(.AW(AW), .PW(PW), .SW(SW), .GW(GW)) u_flash_erase_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqStart(reqStart), .reqLen(reqLen),
    .cfgDevSize(cfgDevSize), .cfgPageSize(cfgPageSize), .cfgPageShift(cfgPageShift),
    .cfgPollGap(cfgPollGap), .spiCs(spiCs), .spiSend(spiSend), .spiTxByte(spiTxByte),
    .spiAck(spiAck), .spiRxByte(spiRxByte), .busy(busy), .done(done), .reject(reject)
  );

  always #2 clk = ~clk;

  int nChecks = 0, nFail = 0;
  bit finished = 1'b0;

  // transaction log filled by the responder
  logic [7:0] logByte [LOGN][4];
  int         logLen  [LOGN];
  int         logGap  [LOGN];
  logic [7:0] logStat [LOGN];
  int nLog = 0;

  // expected erase commands
  logic [7:0]  expOp   [256];
  logic [23:0] expAddr [256];
  int nExp = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic buildExp(input int startPage, input int nPages);
    int p = startPage;
    int n = nPages;
    nExp = 0;
    while (n > 0) begin
      bit blk = ((p % 8) == 0) && (n >= 8);
      expOp[nExp]   = blk ? 8'h50 : 8'h81;
      expAddr[nExp] = 24'(p << cfgPageShift);
      nExp++;
      p += blk ? 8 : 1;
      n -= blk ? 8 : 1;
    end
  endtask

  // byte engine model: random ack delays, random not-ready statuses
  initial begin
    bit prevCs = 1'b0;
    int pos = 0, lowRun = 0, startGap = 0, delay = 0, notReady = 1;
    logic [7:0] cur [4];
    logic [7:0] curStat = 8'h00;
    for (int k = 0; k < 4; k++) cur[k] = 8'h00;
    forever begin
      @(negedge clk);
      if (prevCs && !spiCs) begin
        if (nLog < LOGN) begin
          for (int k = 0; k < 4; k++) logByte[nLog][k] = cur[k];
          logLen[nLog]  = pos;
          logGap[nLog]  = startGap;
          logStat[nLog] = curStat;
        end
        nLog++;
      end
      if (!prevCs && spiCs) begin
        pos = 0;
        startGap = lowRun;
        for (int k = 0; k < 4; k++) cur[k] = 8'h00;
      end
      lowRun = spiCs ? 0 : lowRun + 1;
      prevCs = spiCs;
      if (spiAck) spiAck = 1'b0;
      else if (spiSend) begin
        if (delay > 0) delay--;
        else begin
          if (pos < 4) cur[pos] = spiTxByte;
          if (pos == 1 && cur[0] == 8'hD7) begin
            if (notReady > 0) begin
              spiRxByte = 8'($urandom % 128);
              notReady--;
            end else begin
              spiRxByte = 8'h80 | 8'($urandom % 128);
              notReady = $urandom % 3;
            end
            curStat = spiRxByte;
          end else spiRxByte = 8'($urandom);
          spiAck = 1'b1;
          pos++;
          delay = $urandom % 3;
        end
      end
    end
  end

  task automatic setGeom(input int sel, input int gap);
    case (sel)
      0: begin cfgPageSize = PW'(256); cfgPageShift = SW'(8);  end
      1: begin cfgPageSize = PW'(264); cfgPageShift = SW'(9);  end
      default: begin cfgPageSize = PW'(528); cfgPageShift = SW'(10); end
    endcase
    cfgDevSize = AW'(64 * int'(cfgPageSize));
    cfgPollGap = GW'(gap);
  endtask

  // issue one request and check the outcome and the traffic it caused
  task automatic runReq(input int startByte, input int lenByte, input bit expRej,
                        input string rejReq);
    int cyc = 0;
    int doneCnt = 0;
    bit got = 1'b0, busyOk = 1'b1, gotRej = 1'b0;
    int ps = int'(cfgPageSize);
    nLog = 0;
    if (!expRej) buildExp(startByte / ps, lenByte / ps);
    @(negedge clk);
    reqStart = AW'(startByte);
    reqLen   = AW'(lenByte);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    while (!got && cyc < 20000) begin
      if (done || reject) begin
        got = 1'b1;
        gotRej = reject;
        if (done) doneCnt++;
        check(!busy, "R8", "busy low at result", busy, 0);
      end else begin
        if (!busy) busyOk = 1'b0;
        @(negedge clk);
        cyc++;
      end
    end
    check(got, "R8", "request finished", cyc, 0);
    check(busyOk, "R8", "busy held until result", busyOk, 1);
    repeat (3) begin
      @(negedge clk);
      if (done) doneCnt++;
    end
    if (expRej) begin
      check(gotRej, rejReq, "reject pulse", gotRej, 1);
      check(doneCnt == 0, rejReq, "no done on refusal", doneCnt, 0);
      check(nLog == 0, rejReq, "no traffic on refusal", nLog, 0);
    end else begin
      int ei = 0;
      int i = 0;
      bit opOk = 1'b1, addrOk = 1'b1, lenOk = 1'b1, gapOk = 1'b1, pollOk = 1'b1;
      check(!gotRej, "R2", "no reject on valid request", gotRej, 0);
      check(doneCnt == 1, "R8", "single done pulse", doneCnt, 1);
      while (i < nLog && i < LOGN) begin
        int j;
        bit seenReady = 1'b0;
        if (logByte[i][0] == 8'hD7 || ei >= nExp) begin
          pollOk = 1'b0;
          i++;
          continue;
        end
        if (logByte[i][0] != expOp[ei]) opOk = 1'b0;
        if (logByte[i][1] != expAddr[ei][23:16] || logByte[i][2] != expAddr[ei][15:8]
            || logByte[i][3] != 8'h00) addrOk = 1'b0;
        if (logLen[i] != 4) lenOk = 1'b0;
        ei++;
        j = i + 1;
        while (j < nLog && j < LOGN && logByte[j][0] == 8'hD7) begin
          if (seenReady) pollOk = 1'b0;
          if (logStat[j][7]) seenReady = 1'b1;
          if (logLen[j] != 2 || logByte[j][1] != 8'h00) pollOk = 1'b0;
          if (logGap[j] != int'(cfgPollGap) + 1) gapOk = 1'b0;
          j++;
        end
        if (!seenReady) pollOk = 1'b0;
        i = j;
      end
      check(opOk, "R3", "erase opcodes", opOk, 1);
      check(addrOk, "R4", "command address bytes", addrOk, 1);
      check(lenOk, "R9", "four bytes under one chip select", lenOk, 1);
      check(pollOk, "R5", "status polling until ready", pollOk, 1);
      check(gapOk, "R6", "idle gap before status read", gapOk, 1);
      check(ei == nExp, "R7", "erase command count", ei, nExp);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    setGeom(1, 2);
    repeat (3) @(negedge clk);
    check(!busy && !spiCs && !done && !reject, "R8", "reset state",
          {busy, spiCs, done, reject}, 0);
    check(!spiSend, "R9", "no send after reset", spiSend, 0);
    rstN = 1'b1;
    @(negedge clk);

    // directed: aligned full block
    runReq(0, 8 * 264, 1'b0, "R2");
    // unaligned start, mixes page erases then block
    runReq(3 * 264, 16 * 264, 1'b0, "R2");
    // block, block, page
    setGeom(0, 0);
    runReq(8 * 256, 17 * 256, 1'b0, "R2");
    // seven pages from zero: pages only
    setGeom(2, 4);
    runReq(0, 7 * 528, 1'b0, "R2");
    // last page of device
    runReq(63 * 528, 528, 1'b0, "R2");
    // zero length
    runReq(5 * 528, 0, 1'b0, "R2");
    check(nLog == 0, "R8", "zero length sends nothing", nLog, 0);
    // refusals
    setGeom(1, 1);
    runReq(63 * 264, 2 * 264, 1'b1, "R1");
    runReq(64 * 264, 0, 1'b0, "R2");
    runReq(2 * 264 + 5, 264, 1'b1, "R2");
    runReq(2 * 264, 264 + 1, 1'b1, "R2");
    setGeom(0, 3);
    runReq(17, 0, 1'b1, "R2");

    // constrained random
    for (int t = 0; t < 20; t++) begin
      int sp, np;
      setGeom($urandom % 3, $urandom % 4);
      sp = $urandom % 50;
      np = $urandom % 21;
      if (sp + np > 64) np = 64 - sp;
      runReq(sp * int'(cfgPageSize), np * int'(cfgPageSize), 1'b0, "R2");
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL R8 watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end
endmodule